// File: doc/BRIEF.md
# Programmable Colour Matrix Unit

This unit converts a stream of three-component pixels through a programmable 3x3 matrix. A per-channel offset is then added, and a shared power-of-two gain is applied. It serves for RGB to YCbCr, YCbCr to RGB, or a plain pass-through, depending only on the loaded parameters. Each result is rounded to the nearest integer and limited either to the full 0..255 range or to video range.

The pixel ports use a valid/ready handshake and run at one pixel per cycle when the consumer is ready. Six 32-bit parameter words are written through a simple write port into a staging set. The staging set becomes the working set on the pixel that carries the start-of-frame marker, so a frame never mixes two parameter sets.

Top module: `color_matrix`

## Requirements
- R1: After reset, outValid is low and inReady is high.
- R2: Coefficients are signed 9-bit values. Word 0 bits [26:18], [17:9] and [8:0] hold c00, c11 and c22. Word 2 holds c01, c10 and c20 at the same positions. Word 4 holds c02, c12 and c21. Here cRC is the gain from input column C to output row R.
- R3: Each channel k (0..2) has a signed 13-bit offset. Its bits [4:0] sit in word 2k bits [31:27], and its bits [12:5] sit in word 2k+1 bits [7:0]. Word 1 bits [9:8] hold the scale and word 1 bit 10 holds the saturate enable. Writes to addresses 6 and 7 change nothing.
- R4: Output i equals round((sum over j of cij*xj/256 + offset_i/4) * 2^(scale-1)), with the halfway case rounded up.
- R5: When saturate is off, every output is clamped to 0..255.
- R6: When saturate is on, output 0 is clamped to 16..235 and outputs 1 and 2 are clamped to 16..240.
- R7: With outReady held high, a pixel accepted at one clock edge is presented three edges later. inReady stays high whenever outReady is high.
- R8: While outValid is high and outReady is low, the output data holds steady. No pixel is lost, duplicated or reordered.
- R9: Parameter writes go to a staging set. The pixel accepted with inSof high and every later pixel use the staged values. Pixels accepted before that marker use the previous set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Parameter word write strobe |
| cfgAddr | input | 3 | Parameter word index 0..5 |
| cfgData | input | 32 | Parameter word value |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted when high with inValid |
| inSof | input | 1 | Input pixel is the first of a frame |
| inC0 | input | 8 | Input component 0 |
| inC1 | input | 8 | Input component 1 |
| inC2 | input | 8 | Input component 2 |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Consumer ready |
| outC0 | output | 8 | Output component 0 (luma or R) |
| outC1 | output | 8 | Output component 1 |
| outC2 | output | 8 | Output component 2 |

## Verification
The properties assume that the consumer honours the handshake: data is taken only on a cycle with both outValid and outReady. They also assume that reset is held long enough to empty the pipeline. The latency property further assumes that outReady was high on the two edges after acceptance, and the stimulus produces that case in a dedicated back-to-back run. Elsewhere, inValid and outReady are toggled pseudo-randomly. Parameter writes overlap with pixel traffic in the middle of a frame, which exercises the staging hand-over under stall.

// File: rtl/color_matrix_pkg.sv
package color_matrix_pkg;
  localparam int COEF_W    = 9;
  localparam int OFFS_W    = 13;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 6;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int NUM_CH    = 3;

  // coef[row][col]: gain from input col to output row
  typedef struct packed {
    logic [NUM_CH-1:0][NUM_CH-1:0][COEF_W-1:0] coef;
    logic [NUM_CH-1:0][OFFS_W-1:0]             offs;
    logic [1:0]                                scale;
    logic                                      sat;
  } mtx_cfg_t;

  // per-stage load strobes from control to datapath
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } pipe_stb_t;
endpackage

// File: rtl/color_matrix_ctrl.sv
module color_matrix_ctrl
  import color_matrix_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output pipe_stb_t         stb,
  output mtx_cfg_t          cfgUse
);
  mtx_cfg_t stageCfg, liveCfg;
  logic     v1, v2, v3, rdy1, rdy2, rdy3, take;
  logic     unusedCfgHi;

  assign unusedCfgHi = ^cfgData[WORD_W-1:11];

  // staging set: each write lands in the fields that word owns
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCfg <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        3'd0: begin
          stageCfg.offs[0][4:0] <= cfgData[31:27];
          stageCfg.coef[0][0]   <= cfgData[26:18];
          stageCfg.coef[1][1]   <= cfgData[17:9];
          stageCfg.coef[2][2]   <= cfgData[8:0];
        end
        3'd1: begin
          stageCfg.offs[0][12:5] <= cfgData[7:0];
          stageCfg.scale         <= cfgData[9:8];
          stageCfg.sat           <= cfgData[10];
        end
        3'd2: begin
          stageCfg.offs[1][4:0] <= cfgData[31:27];
          stageCfg.coef[0][1]   <= cfgData[26:18];
          stageCfg.coef[1][0]   <= cfgData[17:9];
          stageCfg.coef[2][0]   <= cfgData[8:0];
        end
        3'd3: stageCfg.offs[1][12:5] <= cfgData[7:0];
        3'd4: begin
          stageCfg.offs[2][4:0] <= cfgData[31:27];
          stageCfg.coef[0][2]   <= cfgData[26:18];
          stageCfg.coef[1][2]   <= cfgData[17:9];
          stageCfg.coef[2][1]   <= cfgData[8:0];
        end
        3'd5: stageCfg.offs[2][12:5] <= cfgData[7:0];
        default: ;
      endcase
    end
  end

  // hand-over on the first pixel of a frame; that pixel already uses it
  assign take   = inValid && inReady && inSof;
  assign cfgUse = take ? stageCfg : liveCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     liveCfg <= '0;
    else if (take) liveCfg <= stageCfg;
  end

  // per-stage ready chain: a full stage may refill while draining
  assign rdy3     = !v3 || outReady;
  assign rdy2     = !v2 || rdy3;
  assign rdy1     = !v1 || rdy2;
  assign inReady  = rdy1;
  assign outValid = v3;

  assign stb.ld1 = inValid && rdy1;
  assign stb.ld2 = v1 && rdy2;
  assign stb.ld3 = v2 && rdy3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      if (stb.ld1)   v1 <= 1'b1;
      else if (rdy2) v1 <= 1'b0;
      if (stb.ld2)   v2 <= 1'b1;
      else if (rdy3) v2 <= 1'b0;
      if (stb.ld3)   v3 <= 1'b1;
      else if (outReady) v3 <= 1'b0;
    end
  end
endmodule

// File: rtl/color_matrix_dp.sv
module color_matrix_dp
  import color_matrix_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pipe_stb_t                    stb,
  input  mtx_cfg_t                     cfg,
  input  logic [NUM_CH-1:0][PIX_W-1:0] pixIn,
  output logic [NUM_CH-1:0][PIX_W-1:0] pixOut
);
  localparam int PROD_W   = COEF_W + PIX_W + 1;
  localparam int SUM_W    = PROD_W + 2;
  localparam int BASE_W   = ((SUM_W + 1 > OFFS_W + 7) ? SUM_W + 1 : OFFS_W + 7) + 1;
  localparam int ACC_W    = BASE_W + 3;
  localparam int FRAC_SH  = 10;
  localparam int RND_HALF = 1 << (FRAC_SH - 1);
  localparam int PIX_MAX  = (1 << PIX_W) - 1;
  localparam int VSH      = PIX_W - 8;

  logic signed [PROD_W-1:0] prodQ1 [NUM_CH][NUM_CH];
  logic signed [OFFS_W-1:0] offsQ1 [NUM_CH];
  logic [1:0]               scaleQ1;
  logic                     satQ1, satQ2;
  logic signed [ACC_W-1:0]  accQ2 [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleQ1 <= '0;
      satQ1   <= 1'b0;
      satQ2   <= 1'b0;
    end else begin
      if (stb.ld1) begin
        scaleQ1 <= cfg.scale;
        satQ1   <= cfg.sat;
      end
      if (stb.ld2) satQ2 <= satQ1;
    end
  end

  for (genvar r = 0; r < NUM_CH; r++) begin : g_row
    localparam int SAT_HI = ((r == 0) ? 235 : 240) << VSH;
    localparam int SAT_LO = 16 << VSH;

    logic signed [ACC_W-1:0] sumExt, offExt, baseV, scaledV, biased;
    logic signed [31:0]      rndExt, loV, hiV;
    logic [PIX_W-1:0]        clampV;

    // stage 1: nine products, signed coefficient times unsigned pixel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_col
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        prodQ1[r][c] <= '0;
        else if (stb.ld1) prodQ1[r][c] <= PROD_W'($signed(cfg.coef[r][c]))
                                        * PROD_W'($signed({1'b0, pixIn[c]}));
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        offsQ1[r] <= '0;
      else if (stb.ld1) offsQ1[r] <= $signed(cfg.offs[r]);
    end

    // stage 2: sum, add offset in 2^-9 units, apply 2^scale
    always_comb begin
      sumExt  = ACC_W'(prodQ1[r][0]) + ACC_W'(prodQ1[r][1]) + ACC_W'(prodQ1[r][2]);
      offExt  = ACC_W'(offsQ1[r]);
      baseV   = (sumExt <<< 1) + (offExt <<< 7);
      scaledV = baseV <<< scaleQ1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        accQ2[r] <= '0;
      else if (stb.ld2) accQ2[r] <= scaledV;
    end

    // stage 3: round half up, then clamp to the selected range
    always_comb begin
      biased = accQ2[r] + ACC_W'(RND_HALF);
      rndExt = 32'($signed(biased[ACC_W-1:FRAC_SH]));
      loV    = satQ2 ? SAT_LO : 0;
      hiV    = satQ2 ? SAT_HI : PIX_MAX;
      if (rndExt < loV)      clampV = loV[PIX_W-1:0];
      else if (rndExt > hiV) clampV = hiV[PIX_W-1:0];
      else                   clampV = rndExt[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        pixOut[r] <= '0;
      else if (stb.ld3) pixOut[r] <= clampV;
    end
  end
endmodule

// File: rtl/color_matrix.sv
module color_matrix
  import color_matrix_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inSof,
  input  logic [PIX_W-1:0]  inC0,
  input  logic [PIX_W-1:0]  inC1,
  input  logic [PIX_W-1:0]  inC2,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outC0,
  output logic [PIX_W-1:0]  outC1,
  output logic [PIX_W-1:0]  outC2
);
  pipe_stb_t                    stb;
  mtx_cfg_t                     cfgUse;
  logic [NUM_CH-1:0][PIX_W-1:0] pixOut;

  color_matrix_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inSof(inSof), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .stb(stb), .cfgUse(cfgUse)
  );

  color_matrix_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfgUse),
    .pixIn({inC2, inC1, inC0}), .pixOut(pixOut)
  );

  assign outC0 = pixOut[0];
  assign outC1 = pixOut[1];
  assign outC2 = pixOut[2];
endmodule

// File: rtl/color_matrix_chk.sv
module color_matrix_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outC0,
  input logic [PIX_W-1:0] outC1,
  input logic [PIX_W-1:0] outC2
);
  logic [2:0] occ;
  logic       inFire, outFire;

  assign inFire  = inValid && inReady;
  assign outFire = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else       occ <= occ + 3'(inFire) - 3'(outFire);
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outC0) && $stable(outC1) && $stable(outC2));

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> occ != 3'd0);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= 3'd3);

  // R7
  full_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inFire && rstN, 3) && $past(outReady, 2) && $past(outReady, 1) |-> outValid);
endmodule

bind color_matrix color_matrix_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady),
  .outC0(outC0), .outC1(outC1), .outC2(outC2)
);

// File: tb/color_matrix_bench.sv
`timescale 1ns/1ps
module color_matrix_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        inValid = 1'b0, inSof = 1'b0, outReady = 1'b0;
  logic [7:0]  inC0 = '0, inC1 = '0, inC2 = '0;
  logic        inReady, outValid;
  logic [7:0]  outC0, outC1, outC2;

  always #2.5 clk = ~clk;

  color_matrix u_color_matrix (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inReady(inReady), .inSof(inSof),
    .inC0(inC0), .inC1(inC1), .inC2(inC2),
    .outValid(outValid), .outReady(outReady),
    .outC0(outC0), .outC1(outC1), .outC2(outC2)
  );

  int          checks = 0, failures = 0;
  bit          finished = 1'b0;
  int unsigned seed = 32'h1234_5678;
  logic [31:0] shadow [6];
  logic [31:0] active [6];
  logic [31:0] pw [6];
  logic [23:0] expQ [$];
  string       tagQ [$];
  string       curReq = "R4";
  bit          holdPend = 1'b0;
  logic [23:0] heldData;

  function automatic int rnd(int n);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 8) % n);
  endfunction

  function automatic int sx(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  function automatic int fld(logic [31:0] w, int lsb, int bits);
    return int'((w >> lsb) & ((32'd1 << bits) - 1));
  endfunction

  // behavioural reference built from the requirement text
  function automatic logic [23:0] model(input logic [31:0] w [6], input int x0, x1, x2);
    int c [3][3];
    int o [3];
    int x [3];
    int sc, st, s, v, r, lo, hi;
    logic [23:0] res;
    x[0] = x0; x[1] = x1; x[2] = x2;
    c[0][0] = sx(fld(w[0], 18, 9), 9); c[1][1] = sx(fld(w[0], 9, 9), 9); c[2][2] = sx(fld(w[0], 0, 9), 9);
    c[0][1] = sx(fld(w[2], 18, 9), 9); c[1][0] = sx(fld(w[2], 9, 9), 9); c[2][0] = sx(fld(w[2], 0, 9), 9);
    c[0][2] = sx(fld(w[4], 18, 9), 9); c[1][2] = sx(fld(w[4], 9, 9), 9); c[2][1] = sx(fld(w[4], 0, 9), 9);
    for (int k = 0; k < 3; k++)
      o[k] = sx(fld(w[2*k], 27, 5) | (fld(w[2*k+1], 0, 8) << 5), 13);
    sc = fld(w[1], 8, 2);
    st = fld(w[1], 10, 1);
    res = '0;
    for (int i = 0; i < 3; i++) begin
      s = c[i][0]*x[0] + c[i][1]*x[1] + c[i][2]*x[2];
      v = (2*s + 128*o[i]) * (1 << sc);
      r = (v + 512) >>> 10;
      lo = st ? 16 : 0;
      hi = st ? ((i == 0) ? 235 : 240) : 255;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      res[8*i +: 8] = 8'(r);
    end
    return res;
  endfunction

  function automatic void packSet(input int cf [9], input int of [3], input int sc, input int st);
    for (int k = 0; k < 3; k++)
      pw[2*k+1] = 32'((of[k] >> 5) & 255);
    pw[1] = pw[1] | 32'((sc & 3) << 8) | 32'((st & 1) << 10);
    pw[0] = 32'(((of[0] & 31) << 27) | ((cf[0] & 511) << 18) | ((cf[4] & 511) << 9) | (cf[8] & 511));
    pw[2] = 32'(((of[1] & 31) << 27) | ((cf[1] & 511) << 18) | ((cf[3] & 511) << 9) | (cf[6] & 511));
    pw[4] = 32'(((of[2] & 31) << 27) | ((cf[2] & 511) << 18) | ((cf[5] & 511) << 9) | (cf[7] & 511));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, evaluate handshakes before the rising edge
  task automatic cyc(input bit v, input bit s, input int a, input int b, input int c,
                     input bit r, input bit we, input int ad, input logic [31:0] d);
    logic [23:0] e;
    @(negedge clk);
    if (holdPend)  // R8
      check(outValid && {outC2, outC1, outC0} == heldData, "R8", {7'd0, outValid, outC2, outC1, outC0}, {8'd1, heldData});
    inValid = v; inSof = s; inC0 = 8'(a); inC1 = 8'(b); inC2 = 8'(c);
    outReady = r; cfgWe = we; cfgAddr = 3'(ad); cfgData = d;
    #1;
    if (r) check(inReady, "R7", 32'(inReady), 32'd1);
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", {8'd0, outC2, outC1, outC0}, 32'hFFFF_FFFF);
      end else begin
        e = expQ.pop_front();
        check({outC2, outC1, outC0} == e, tagQ.pop_front(), {8'd0, outC2, outC1, outC0}, {8'd0, e});
      end
    end
    holdPend = outValid && !outReady;
    heldData = {outC2, outC1, outC0};
    if (inValid && inReady) begin
      if (inSof) active = shadow;  // R9
      expQ.push_back(model(active, a, b, c));
      tagQ.push_back(curReq);
    end
    if (we && ad < 6) shadow[ad] = d;
  endtask

  task automatic idle(input bit r);
    cyc(1'b0, 1'b0, 0, 0, 0, r, 1'b0, 0, '0);
  endtask

  task automatic loadPw();
    for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, 0, 0, 0, 1'b1, 1'b1, k, pw[k]);
  endtask

  // n pixels, first carries the frame marker, random gaps and backpressure
  task automatic frame(input int n, input bit sof, input int vPct, input int rPct);
    int sent = 0;
    bit first = sof;
    while (sent < n) begin
      if (rnd(100) < vPct) begin
        cyc(1'b1, first, rnd(256), rnd(256), rnd(256), rnd(100) < rPct, 1'b0, 0, '0);
        if (inValid && inReady) begin sent++; first = 1'b0; end
      end else begin
        idle(rnd(100) < rPct);
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && (expQ.size() != 0 || outValid); k++) idle(1'b1);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) begin shadow[k] = '0; active[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1
    check(!outValid && inReady, "R1", {30'd0, outValid, inReady}, 32'd1);

    // YCbCr to RGB, full-range clamp
    curReq = "R5";
    packSet('{149, 0, 204, 149, 462, 408, 149, 255, 0}, '{-446, 266, -554}, 2, 0);
    loadPw();
    cyc(1'b1, 1'b1, 0, 0, 0, 1'b1, 1'b0, 0, '0);
    cyc(1'b1, 1'b0, 255, 255, 255, 1'b1, 1'b0, 0, '0);
    cyc(1'b1, 1'b0, 16, 128, 128, 1'b1, 1'b0, 0, '0);
    frame(60, 1'b0, 75, 70);

    // mid-frame staging of RGB to YCbCr with saturation (R9)
    curReq = "R9";
    packSet('{77, 150, 29, 469, 427, 128, 128, 405, 491}, '{0, 512, 512}, 1, 1);
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, rnd(256), rnd(256), rnd(256), rnd(2) == 1, 1'b1, k, pw[k]);
    frame(10, 1'b0, 80, 60);
    curReq = "R6";
    cyc(1'b1, 1'b1, 0, 0, 0, 1'b0, 1'b0, 0, '0);
    while (!(inValid && inReady)) cyc(1'b1, 1'b1, 0, 0, 0, 1'b1, 1'b0, 0, '0);
    cyc(1'b1, 1'b0, 255, 255, 255, 1'b0, 1'b0, 0, '0);
    frame(40, 1'b0, 80, 60);
    drain();

    // identity with ignored addresses 6 and 7 (R3)
    curReq = "R3";
    packSet('{128, 0, 0, 0, 128, 0, 0, 0, 128}, '{0, 0, 0}, 2, 0);
    loadPw();
    cyc(1'b0, 1'b0, 0, 0, 0, 1'b1, 1'b1, 6, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b0, 0, 0, 0, 1'b1, 1'b1, 7, 32'h5555_5555);
    cyc(1'b1, 1'b1, 10, 200, 255, 1'b1, 1'b0, 0, '0);
    frame(20, 1'b0, 90, 80);

    // gain via scale, then arbitrary packed sets (R4, R2)
    curReq = "R4";
    for (int sc = 0; sc < 4; sc++) begin
      packSet('{128, 0, 0, 0, 128, 0, 0, 0, 128}, '{6, -6, 2}, sc, 0);
      loadPw();
      frame(12, 1'b1, 85, 75);
    end
    curReq = "R2";
    for (int t = 0; t < 6; t++) begin
      packSet('{rnd(512), rnd(512), rnd(512), rnd(512), rnd(512), rnd(512), rnd(512), rnd(512), rnd(512)},
              '{rnd(8192), rnd(8192), rnd(8192)}, rnd(4), rnd(2));
      loadPw();
      frame(30, 1'b1, 80, 70);
    end
    drain();

    // R7: three-edge latency and back-to-back rate
    curReq = "R7";
    cyc(1'b1, 1'b0, 1, 2, 3, 1'b1, 1'b0, 0, '0);
    idle(1'b1); check(!outValid, "R7", 32'(outValid), 32'd0);
    idle(1'b1); check(!outValid, "R7", 32'(outValid), 32'd0);
    idle(1'b1); check(outValid, "R7", 32'(outValid), 32'd1);
    for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, rnd(256), rnd(256), rnd(256), 1'b1, 1'b0, 0, '0);
    drain();
    // R8: nothing left behind
    check(expQ.size() == 0 && !outValid, "R8", 32'(expQ.size()), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule